// File: doc/BRIEF.md
# Tree Ancestry Mask Generator

This block turns a draft tree of speculative candidate tokens into the binary attention mask that the verification pass needs. Each verification step, the tree-management logic presents the node count and a parent index for every node, then pulses a start strobe. The block walks the nodes once in index order. It forms each node's mask row from the row of that node's parent, so an N-node tree is finished in N+1 cycles, and keeps the rows in a small local row store.

The attention datapath reads the finished rows through a one-cycle read port. A row has a 1 in column j exactly when node j is that node or one of its ancestors, so the pattern follows the tree rather than a fixed lower-triangular shape. A new start strobe discards the previous tree at any time, even while a walk is still running, so the block needs no setup between steps. A sticky error flag reports a tree that breaks the ordering rule or goes deeper than the configured depth limit.

Top module: `anc_mask_gen`

## Requirements
- R1: While reset is held low and after it is released, `done` is 0, `tree_err` is 0 and `rd_row` is all zeros.
- R2: The parent of node k (k >= 1) is taken from bits [k*AW +: AW] of `parent_list`, where AW = log2(MAX_NODES). Entry 0 is ignored and node 0 is the root. Bit j of row i is 1 exactly when j = i, or when j is reached from i by following parent indices.
- R3: `done` is 0 for the first N clock edges after the edge that samples `start`. It is 1 from edge N+1 onward, until the next start. Here N is the clamped node count.
- R4: `rd_row` shows the row addressed by `rd_addr` one clock edge after the address is sampled.
- R5: A read of any address at or above N, up to 2*MAX_NODES-1, returns all zeros. So does a read of a row the current walk has not yet written.
- R6: A start strobe discards the previous tree, even in the middle of a walk. Only rows of the new tree are then visible, and the completion timing restarts.
- R7: A node count above MAX_NODES is treated as MAX_NODES. A node count of 0 produces no rows and raises `done` one edge after start.
- R8: A node k >= 1 whose parent index is not smaller than k is treated as a root. Its row is only its own bit, and `tree_err` is set.
- R9: `tree_err` is set when any node below N lies more than MAX_DEPTH parent steps from a root. It is cleared by the next start and stays set until then.
- R10: A read of the row being written on the same edge returns the value from before the write, which is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that loads a new tree |
| node_count | input | AW+1 | Number of nodes N, sampled with start |
| parent_list | input | MAX_NODES*AW | Parent index per node, sampled with start |
| rd_addr | input | AW+1 | Row read address |
| rd_row | output | MAX_NODES | Mask row, one cycle after its address |
| done | output | 1 | All N rows are valid |
| tree_err | output | 1 | Ordering or depth violation in the current tree |

## Verification
Two functions can fall in the same cycle. The read port can address the row that the walk writes on that same edge, and a start strobe can arrive while an earlier walk is still writing. The first case is provoked by holding the read address on row 0 and then row 1 as the walk passes them. Each read must return zeros on the edge of the write and the finished row on the next edge. The second case is provoked by starting a smaller tree three cycles into a larger one. The completion count must restart, and the rows left over from the abandoned walk must read as zeros.

// File: rtl/amg_pkg.sv
// Shared definitions for the tree ancestry mask generator.
package amg_pkg;
    // Walk sequencer states.
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_t;
endpackage

// File: rtl/amg_walk_ctrl.sv
// Walk sequencer: on start it captures the clamped node count and then steps
// through node indices 0..N-1, one write per cycle, and raises done once the
// walk is over. It assumes the parent of each node has already been written
// when that node is visited (parents have smaller indices).
module amg_walk_ctrl #(
    parameter int MAX_NODES = 16,
    localparam int AW = $clog2(MAX_NODES),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] n_in,
    output logic [CW-1:0] n_q,
    output logic          done,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx
);
    import amg_pkg::*;

    localparam logic [CW-1:0] NMAX = CW'(MAX_NODES);

    walk_state_t   st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] n_clamped;

    // Limit the requested node count to the node budget.
    always_comb n_clamped = (n_in > NMAX) ? NMAX : n_in;

    // Sequencer state, node counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= WALK_IDLE;
            cnt  <= '0;
            n_q  <= '0;
            done <= 1'b0;
        end else if (start) begin
            st   <= WALK_RUN;
            cnt  <= '0;
            n_q  <= n_clamped;
            done <= 1'b0;
        end else if (st == WALK_RUN) begin
            if (cnt == n_q) begin
                st   <= WALK_IDLE;
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // A row is written on every walking cycle except the closing one.
    always_comb begin
        wr_en  = (st == WALK_RUN) && (cnt != n_q) && !start;
        wr_idx = cnt[AW-1:0];
    end

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);                                         // R3
    AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);                                         // R3
    AST_WRITE_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (CW'(wr_idx) < n_q));                           // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);                                 // R3
endmodule

// File: rtl/amg_parent_reg.sv
// Parent table and depth tracker: it captures the parent list on start,
// supplies the parent of the node being written, and keeps the depth of
// every written node. It raises a sticky error for a parent that does not
// precede its child or for a node deeper than MAX_DEPTH. A node with an
// invalid parent is treated as a root of depth 0.
module amg_parent_reg #(
    parameter int MAX_NODES = 16,
    parameter int MAX_DEPTH = 6,
    localparam int AW = $clog2(MAX_NODES),
    localparam int DW = $clog2(MAX_DEPTH + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [MAX_NODES*AW-1:0] parent_list,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_idx,
    output logic [AW-1:0]           par_idx,
    output logic                    par_ok,
    output logic                    tree_err
);
    localparam logic [DW-1:0] DSAT = DW'(MAX_DEPTH + 1);
    localparam logic [DW-1:0] DLIM = DW'(MAX_DEPTH);

    logic [AW-1:0] plist_q [MAX_NODES];
    logic [DW-1:0] dep_q   [MAX_NODES];
    logic [DW-1:0] par_dep;
    logic [DW-1:0] node_dep;
    logic          bad_par;

    // Capture the parent table when a new tree is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_NODES; k++) plist_q[k] <= '0;
        end else if (start) begin
            for (int k = 0; k < MAX_NODES; k++) plist_q[k] <= parent_list[k*AW +: AW];
        end
    end

    // Look up the current node's parent and derive its depth.
    always_comb begin
        par_idx  = plist_q[wr_idx];
        par_ok   = (wr_idx != '0) && (par_idx < wr_idx);
        bad_par  = (wr_idx != '0) && !par_ok;
        par_dep  = dep_q[par_idx];
        if (!par_ok)
            node_dep = '0;
        else if (par_dep >= DSAT)
            node_dep = DSAT;
        else
            node_dep = par_dep + 1'b1;
    end

    // Record node depths as rows are written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_NODES; k++) dep_q[k] <= '0;
        end else if (wr_en) begin
            dep_q[wr_idx] <= node_dep;
        end
    end

    // Sticky error flag, cleared by each new tree.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tree_err <= 1'b0;
        else if (start)
            tree_err <= 1'b0;
        else if (wr_en && (bad_par || node_dep > DLIM))
            tree_err <= 1'b1;
    end

    AST_ERR_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !tree_err);                                     // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tree_err && !start |=> tree_err);                         // R9
    AST_BAD_PARENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_idx != '0) && (plist_q[wr_idx] >= wr_idx) |=> tree_err); // R8
endmodule

// File: rtl/amg_row_store.sv
// Row store: holds one mask row per node with a per-row valid bit that is
// cleared on every start. It offers an unregistered lookup of the parent row
// for the walk and a registered read port. A read returns zero for rows not
// yet written or at or above the node count. A read on the edge of a write
// returns the previous contents.
module amg_row_store #(
    parameter int MAX_NODES = 16,
    localparam int AW = $clog2(MAX_NODES),
    localparam int CW = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_idx,
    input  logic [MAX_NODES-1:0] wr_row,
    input  logic [AW-1:0]        par_idx,
    input  logic [CW-1:0]        n_q,
    input  logic [CW-1:0]        rd_addr,
    output logic [MAX_NODES-1:0] par_row,
    output logic [MAX_NODES-1:0] rd_row
);
    logic [MAX_NODES-1:0] mem [MAX_NODES];
    logic [MAX_NODES-1:0] vld;
    logic                 rd_hit;

    // Row data; only rows marked valid are ever observed.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_row;
    end

    // Valid bits: cleared per tree, set as rows are written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= '0;
        else if (start)
            vld <= '0;
        else if (wr_en)
            vld[wr_idx] <= 1'b1;
    end

    // Parent row lookup for the walk.
    always_comb par_row = mem[par_idx];

    // Address qualification for the read port.
    always_comb rd_hit = (rd_addr < n_q) && vld[rd_addr[AW-1:0]];

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_row <= '0;
        else
            rd_row <= rd_hit ? mem[rd_addr[AW-1:0]] : '0;
    end

    AST_WRITE_ONCE_PER_TREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !vld[wr_idx]);                                  // R6
    AST_ROW_NO_LATER_NODES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_row >> wr_idx) == MAX_NODES'(1)));         // R2
    AST_ZERO_BEYOND_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_addr < n_q) |=> (rd_row == '0));                     // R5
endmodule

// File: rtl/anc_mask_gen.sv
// Tree ancestry mask generator top. On start it loads a node count and a
// parent list and walks the nodes in index order, one per cycle. Each row is
// the parent's row with the node's own bit added. Rows are read through a
// one-cycle port. It assumes parents precede children; violations and excess
// depth are reported on tree_err.
module anc_mask_gen #(
    parameter int MAX_NODES = 16,
    parameter int MAX_DEPTH = 6,
    localparam int AW = $clog2(MAX_NODES),
    localparam int CW = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CW-1:0]           node_count,
    input  logic [MAX_NODES*AW-1:0] parent_list,
    input  logic [CW-1:0]           rd_addr,
    output logic [MAX_NODES-1:0]    rd_row,
    output logic                    done,
    output logic                    tree_err
);
    logic [CW-1:0]        n_q;
    logic                 wr_en;
    logic [AW-1:0]        wr_idx;
    logic [AW-1:0]        par_idx;
    logic                 par_ok;
    logic [MAX_NODES-1:0] par_row;
    logic [MAX_NODES-1:0] new_row;

    amg_walk_ctrl #(.MAX_NODES(MAX_NODES)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(node_count),
        .n_q(n_q), .done(done), .wr_en(wr_en), .wr_idx(wr_idx)
    );

    amg_parent_reg #(.MAX_NODES(MAX_NODES), .MAX_DEPTH(MAX_DEPTH)) u_par (
        .clk(clk), .rst_n(rst_n), .start(start), .parent_list(parent_list),
        .wr_en(wr_en), .wr_idx(wr_idx), .par_idx(par_idx), .par_ok(par_ok),
        .tree_err(tree_err)
    );

    // New row: inherited ancestry plus the node itself.
    always_comb new_row = (par_ok ? par_row : '0) | (MAX_NODES'(1) << wr_idx);

    amg_row_store #(.MAX_NODES(MAX_NODES)) u_store (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_row(new_row), .par_idx(par_idx), .n_q(n_q), .rd_addr(rd_addr),
        .par_row(par_row), .rd_row(rd_row)
    );

    AST_DONE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !start || 1'b1 ? (done -> !wr_en) : 1'b1);       // R3
    AST_START_STOPS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && !tree_err);                            // R6
endmodule

// File: tb/anc_mask_gen_test.sv
// Self-checking bench for the tree ancestry mask generator.
module anc_mask_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 16;
    localparam int MAXD = 6;
    localparam int AW = 4;
    localparam int CW = 5;
    localparam int NVEC = 4;

    // Stimulus table: node count and parent list (nibble k = parent of node k).
    localparam logic [CW-1:0] TAB_N [NVEC] = '{5'd5, 5'd6, 5'd7, 5'd9};
    localparam logic [63:0]   TAB_P [NVEC] = '{64'h0000_0000_0003_2100,
                                               64'h0000_0000_0000_0000,
                                               64'h0000_0000_0221_1000,
                                               64'hFEDC_BA07_4211_0000};
    localparam logic [63:0] CHAIN = 64'hEDCB_A987_6543_2100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CW-1:0]   node_count = '0;
    logic [63:0]     parent_list = '0;
    logic [CW-1:0]   rd_addr = '0;
    logic [MAXN-1:0] rd_row;
    logic            done;
    logic            tree_err;

    int total = 0;
    int bad = 0;

    anc_mask_gen #(.MAX_NODES(MAXN), .MAX_DEPTH(MAXD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .node_count(node_count),
        .parent_list(parent_list), .rd_addr(rd_addr), .rd_row(rd_row),
        .done(done), .tree_err(tree_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int par_of(logic [63:0] pl, int j);
        return int'(pl[j*AW +: AW]);
    endfunction

    // Expected row: climb parent links, stopping at a root or a bad link.
    function automatic logic [MAXN-1:0] exp_row(logic [63:0] pl, int n, int i);
        logic [MAXN-1:0] r = '0;
        int j = i;
        if (i >= n) return '0;
        for (int s = 0; s < MAXN; s++) begin
            r[j] = 1'b1;
            if (j == 0) break;
            if (par_of(pl, j) >= j) break;
            j = par_of(pl, j);
        end
        return r;
    endfunction

    // Expected error: any bad link or any node too deep.
    function automatic logic exp_err(logic [63:0] pl, int n);
        logic e = 1'b0;
        for (int i = 1; i < n; i++) begin
            int j = i;
            int d = 0;
            for (int s = 0; s < MAXN; s++) begin
                if (j == 0) break;
                if (par_of(pl, j) >= j) begin e = 1'b1; break; end
                d++;
                j = par_of(pl, j);
            end
            if (d > MAXD) e = 1'b1;
        end
        return e;
    endfunction

    task automatic chk(logic [MAXN-1:0] act, logic [MAXN-1:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_tree(int n, logic [63:0] pl);
        @(negedge clk);
        start = 1'b1;
        node_count = CW'(n);
        parent_list = pl;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_row(int a, output logic [MAXN-1:0] r);
        rd_addr = CW'(a);
        @(negedge clk);
        r = rd_row;
    endtask

    // Load a tree, check completion timing, error flag and every row.
    task automatic run_tree(int n, logic [63:0] pl, string tag);
        int ne = (n > MAXN) ? MAXN : n;
        logic [MAXN-1:0] r;
        load_tree(n, pl);
        repeat (ne) @(negedge clk);
        chk(MAXN'(done), MAXN'(0), {"R3 done early ", tag});
        @(negedge clk);
        chk(MAXN'(done), MAXN'(1), {"R3 done late ", tag});
        chk(MAXN'(tree_err), MAXN'(exp_err(pl, ne)), {"R9 err ", tag});
        for (int a = 0; a < 2*MAXN; a++) begin
            read_row(a, r);
            chk(r, exp_row(pl, ne, a), $sformatf("R2 R4 R5 row %0d %s", a, tag));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [MAXN-1:0] r;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(MAXN'(done), '0, "R1 done in reset");
        chk(rd_row, '0, "R1 rd_row in reset");
        chk(MAXN'(tree_err), '0, "R1 err in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(MAXN'(done), '0, "R1 done after reset");

        // R2: table of trees
        for (int v = 0; v < NVEC; v++)
            run_tree(int'(TAB_N[v]), TAB_P[v], $sformatf("vec%0d", v));

        // R9: depth boundary, exactly MAX_DEPTH then one more
        run_tree(7, CHAIN, "chain7 depth limit");
        run_tree(8, CHAIN, "chain8 too deep");
        // R7: full budget and clamped count
        run_tree(16, CHAIN, "R7 full chain");
        run_tree(20, 64'h0, "R7 clamped star");
        // R8: bad parent makes node 2 a root
        run_tree(5, 64'h0000_0000_0001_2200, "R8 bad parent");
        // R7: empty tree
        run_tree(0, CHAIN, "R7 empty");

        // R6: restart in the middle of a walk
        load_tree(8, CHAIN);
        repeat (2) @(negedge clk);
        run_tree(4, 64'h0, "R6 restart");

        // R10: read collides with write of the same row
        @(negedge clk);
        start = 1'b1;
        node_count = 5'd4;
        parent_list = CHAIN;
        rd_addr = '0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(rd_row, '0, "R10 row0 on write edge");
        rd_addr = 5'd1;
        @(negedge clk);
        chk(rd_row, '0, "R10 row1 on write edge");
        @(negedge clk);
        chk(rd_row, 16'h0003, "R10 row1 after write");
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule